// File: doc/BRIEF.md
# Half-Rate Wavefront Lane Sequencer

This block sits between an instruction front end that advances once every two ALU clocks and a 16-lane ALU array that runs every clock. Each front-end instruction covers a wavefront of 32 threads, but the array has only 16 lanes. The sequencer therefore plays each accepted instruction out over two back-to-back ALU cycles. Threads 0 to 15 go in the first cycle and threads 16 to 31 in the second. In each cycle it presents the instruction, a half-select that tells operand and result indexing which thread half is in flight, and per-lane enables derived from the wavefront's thread-active mask.

The whole design runs on the ALU clock. The slower front-end rate comes from a phase counter inside that domain rather than from a second clock. The counter's first phase is brought out as `fe_ready`, which doubles as the front end's clock enable. An instruction is taken only when `fe_valid` and `fe_ready` are both high. When no instruction is offered, both following ALU cycles are no-ops with every lane enable low. The lane count and the number of halves are parameters; the defaults give 16 lanes and 2 halves.

Top module: `wave_half_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `fe_ready` is 1, `alu_issue` is 0, `alu_half` is 0 and `alu_lane_en` is all zero.
- R2: `fe_ready` is high in every other cycle after reset, starting with the first, and it is low in between. An instruction can be taken at most once per two cycles.
- R3: An instruction accepted at a clock edge (with `fe_valid` and `fe_ready` both 1) appears on `alu_instr` with `alu_issue` high for the next two cycles. `alu_half` is 0 in the first of those cycles and 1 in the second.
- R4: In the first issue cycle, `alu_lane_en[i]` equals bit i of the accepted `fe_mask` (thread i), for i from 0 to 15.
- R5: In the second issue cycle, `alu_lane_en[i]` equals bit 16+i of the accepted `fe_mask` (thread 16+i).
- R6: If `fe_valid` is 0 at an edge where `fe_ready` is 1, the next two cycles have `alu_issue` 0 and `alu_lane_en` all zero, and `alu_half` still steps 0 then 1.
- R7: `fe_valid`, `fe_instr` and `fe_mask` are ignored at edges where `fe_ready` is 0. They do not change the instruction or the lane enables of the second issue cycle.
- R8: An accepted instruction with an all-zero mask still raises `alu_issue` for both cycles, with every lane enable low.
- R9: Instructions offered at every ready edge issue back to back, one every two cycles, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate ALU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid | input | 1 | Front end offers an instruction |
| fe_ready | output | 1 | First phase of the two-cycle slot: instruction taken at this edge; also the front-end clock enable |
| fe_instr | input | 32 | Instruction word from the front end |
| fe_mask | input | 32 | Thread-active mask, bit t for thread t |
| alu_issue | output | 1 | ALU cycle carries a real instruction |
| alu_half | output | 1 | Thread half in flight: 0 for threads 0-15, 1 for threads 16-31 |
| alu_instr | output | 32 | Instruction presented to the lanes |
| alu_lane_en | output | 16 | Per-lane write enable for the current half |

## Verification
The bench attacks the points where the two-phase slicing can slip by a cycle or lose the mask. It drives junk valid, instruction and mask values in every not-ready cycle. A design that sampled the front end during the second phase would show that junk in the upper-half enables or in the instruction. Mask patterns that differ only in one half, including all-zero, all-one and single-half masks, expose a swapped or shifted slice, because the wrong lanes light up in one of the two cycles. Runs of idle slots between busy ones, and long back-to-back runs, catch a design that leaves stale enables set on no-op cycles or that inserts a gap between wavefronts.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    // width of a selector that names one of n items (at least one bit)
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wseq_phase_gen.sv
// Counts ALU cycles within one front-end slot; phase 0 is the accept window.
module wseq_phase_gen #(
    parameter int HALVES = 2,
    localparam int SELW  = wseq_pkg::sel_width(HALVES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [SELW-1:0] phase,
    output logic            first
);
    localparam logic [SELW-1:0] LAST = SELW'(HALVES - 1);

    logic [SELW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign phase = cnt_q;
    assign first = (cnt_q == '0);
endmodule

// File: rtl/wseq_mask_slice.sv
// Picks the LANES-wide slice of the wavefront mask that belongs to one half.
module wseq_mask_slice #(
    parameter int LANES  = 16,
    parameter int HALVES = 2,
    localparam int WAVE  = LANES * HALVES,
    localparam int SELW  = wseq_pkg::sel_width(HALVES)
) (
    input  logic [WAVE-1:0]  mask,
    input  logic [SELW-1:0]  sel,
    output logic [LANES-1:0] lanes
);
    logic [LANES-1:0] part [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_part
        assign part[h] = mask[h*LANES +: LANES];
    end

    always_comb begin
        lanes = '0;
        for (int h = 0; h < HALVES; h++) begin
            if (sel == SELW'(h)) lanes = part[h];
        end
    end
endmodule

// File: rtl/wave_half_sequencer.sv
module wave_half_sequencer #(
    parameter int LANES  = 16,
    parameter int HALVES = 2,
    parameter int IW     = 32,
    localparam int WAVE  = LANES * HALVES,
    localparam int SELW  = wseq_pkg::sel_width(HALVES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fe_valid,
    output logic             fe_ready,
    input  logic [IW-1:0]    fe_instr,
    input  logic [WAVE-1:0]  fe_mask,
    output logic             alu_issue,
    output logic [SELW-1:0]  alu_half,
    output logic [IW-1:0]    alu_instr,
    output logic [LANES-1:0] alu_lane_en
);
    typedef struct packed {
        logic            issue;
        logic [SELW-1:0] half;
        logic [IW-1:0]   instr;
        logic [WAVE-1:0] mask;
    } slot_t;

    slot_t            st_d, st_q;
    logic [SELW-1:0]  phase;
    logic             first;
    logic             take;
    logic [LANES-1:0] slice;

    wseq_phase_gen #(.HALVES(HALVES)) i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .first (first)
    );

    assign take = first && fe_valid;

    always_comb begin
        st_d      = st_q;
        // output half lags the phase counter by the output register
        st_d.half = phase;
        if (first) begin
            st_d.issue = fe_valid;
            st_d.mask  = take ? fe_mask : '0;
            if (take) st_d.instr = fe_instr;   // hold word on no-ops
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    wseq_mask_slice #(.LANES(LANES), .HALVES(HALVES)) i_slice (
        .mask  (st_q.mask),
        .sel   (st_q.half),
        .lanes (slice)
    );

    assign fe_ready    = first;
    assign alu_issue   = st_q.issue;
    assign alu_half    = st_q.half;
    assign alu_instr   = st_q.instr;
    assign alu_lane_en = st_q.issue ? slice : '0;
endmodule

// File: rtl/wseq_checker.sv
module wseq_checker #(
    parameter int LANES  = 16,
    parameter int HALVES = 2,
    parameter int IW     = 32,
    localparam int WAVE  = LANES * HALVES,
    localparam int SELW  = wseq_pkg::sel_width(HALVES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fe_valid,
    input logic             fe_ready,
    input logic [IW-1:0]    fe_instr,
    input logic [WAVE-1:0]  fe_mask,
    input logic             alu_issue,
    input logic [SELW-1:0]  alu_half,
    input logic [IW-1:0]    alu_instr,
    input logic [LANES-1:0] alu_lane_en
);
    localparam logic [SELW-1:0] LAST = SELW'(HALVES - 1);

    logic [LANES-1:0] top_cap_q;
    logic [IW-1:0]    instr_cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_cap_q   <= '0;
            instr_cap_q <= '0;
        end else if (fe_valid && fe_ready) begin
            top_cap_q   <= fe_mask[WAVE-1 -: LANES];
            instr_cap_q <= fe_instr;
        end
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fe_ready |=> !fe_ready);

    assert_take_issues_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && fe_ready) |=> (alu_issue && alu_half == '0 && alu_instr == $past(fe_instr)));

    assert_half_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_issue && alu_half != LAST) |=>
            (alu_issue && alu_half == SELW'($past(alu_half) + 1'b1) && $stable(alu_instr)));

    assert_low_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && fe_ready) |=> (alu_lane_en == $past(fe_mask[LANES-1:0])));

    assert_high_slice_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_issue && alu_half == LAST) |-> (alu_lane_en == top_cap_q));

    assert_ignore_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alu_issue |-> (alu_instr == instr_cap_q));

    assert_idle_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_ready && !fe_valid) |=> (!alu_issue && alu_lane_en == '0 && alu_half == '0));

    assert_noop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_issue |-> (alu_lane_en == '0));
endmodule

bind wave_half_sequencer wseq_checker #(
    .LANES (LANES),
    .HALVES(HALVES),
    .IW    (IW)
) i_wseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fe_valid    (fe_valid),
    .fe_ready    (fe_ready),
    .fe_instr    (fe_instr),
    .fe_mask     (fe_mask),
    .alu_issue   (alu_issue),
    .alu_half    (alu_half),
    .alu_instr   (alu_instr),
    .alu_lane_en (alu_lane_en)
);

// File: tb/test_wave_half_sequencer.sv
`timescale 1ns/1ps
module test_wave_half_sequencer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        fe_valid = 0;
    logic        fe_ready;
    logic [31:0] fe_instr = '0;
    logic [31:0] fe_mask = '0;
    logic        alu_issue;
    logic        alu_half;
    logic [31:0] alu_instr;
    logic [15:0] alu_lane_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        bit          issue;
        bit          half;
        logic [31:0] instr;
        logic [15:0] lanes;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    wave_half_sequencer i_wave_half_sequencer (
        .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_ready(fe_ready),
        .fe_instr(fe_instr), .fe_mask(fe_mask), .alu_issue(alu_issue),
        .alu_half(alu_half), .alu_instr(alu_instr), .alu_lane_en(alu_lane_en)
    );

    task automatic check1(input bit ok, input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: one slot = ready cycle + not-ready cycle carrying junk (R7)
    task automatic send(input bit v, input logic [31:0] ins, input logic [31:0] m,
                        input string tag);
        exp_t e;
        @(negedge clk);
        while (!fe_ready) @(negedge clk);
        check1(fe_ready == 1'b1, "R2", "ready in first phase", 64'(fe_ready), 64'd1);
        fe_valid = v;
        fe_instr = ins;
        fe_mask  = m;
        e.issue = v; e.half = 1'b0; e.instr = ins;
        e.lanes = v ? m[15:0] : 16'h0;
        e.req   = v ? {tag, "/R3/R4"} : "R6";
        sb.push_back(e);
        e.half  = 1'b1;
        e.lanes = v ? m[31:16] : 16'h0;
        e.req   = v ? {tag, "/R3/R5/R7"} : "R6";
        sb.push_back(e);
        @(negedge clk);
        check1(fe_ready == 1'b0, "R2", "ready low in second phase", 64'(fe_ready), 64'd0);
        fe_valid = 1'b1;
        fe_instr = $urandom;
        fe_mask  = $urandom;
    endtask

    // monitor: sample just after each edge, once outputs have settled
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check1(alu_issue == e.issue, e.req, "issue", 64'(alu_issue), 64'(e.issue));
                check1(alu_half == e.half, e.req, "half", 64'(alu_half), 64'(e.half));
                check1(alu_lane_en == e.lanes, e.req, "lanes", 64'(alu_lane_en), 64'(e.lanes));
                if (e.issue)
                    check1(alu_instr == e.instr, e.req, "instr", 64'(alu_instr), 64'(e.instr));
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs while reset is held
        check1(alu_issue == 0 && alu_lane_en == 0 && alu_half == 0, "R1", "in reset",
               {alu_issue, alu_half, alu_lane_en}, 64'd0);
        rst_n = 1'b1;
        #1;
        check1(fe_ready == 1'b1, "R1", "ready after reset", 64'(fe_ready), 64'd1);
        check1(alu_issue == 0 && alu_lane_en == 0 && alu_half == 0, "R1", "idle after reset",
               {alu_issue, alu_half, alu_lane_en}, 64'd0);

        send(1, 32'h1111_0001, 32'hFFFF_FFFF, "R4all");
        send(1, 32'h2222_0002, 32'h0000_FFFF, "R4low");
        send(1, 32'h3333_0003, 32'hFFFF_0000, "R5high");
        send(1, 32'h4444_0004, 32'hA5A5_3C3C, "R5mix");
        send(1, 32'h5555_0005, 32'h0000_0000, "R8");
        send(0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R6");
        send(0, 32'hDEAD_BEEF, 32'h1234_5678, "R6");
        send(1, 32'h6666_0006, 32'h8000_0001, "R5edge");
        send(0, 32'h0, 32'h0, "R6");
        // R9: long back-to-back run with occasional idle slots
        for (int i = 0; i < 40; i++) begin
            send((i % 7) != 6, $urandom, $urandom, "R9");
        end
        @(negedge clk);
        fe_valid = 1'b0;
        repeat (6) @(negedge clk);
        check1(sb.size() == 0, "R9", "scoreboard drained", 64'(sb.size()), 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule